// File: doc/BRIEF.md
# Shared-Pin Multi-Timer Output Controller

This block holds three down-counting timers that all share one bidirectional timer pin. Each timer has a control word, a preload value and a current count, all loaded through a simple write port. An enabled timer decrements once for each event it selects. When it reaches its end of count, it reloads its preload value in that same cycle and raises a zero event. Each timer's output mode sets what its zero events do to the shared pin. The pin can pulse high for one clock, invert its level, or stay untouched by that timer. Any timer may instead count rising edges of the pin's input, after those edges pass through a two-flop synchronizer.

Zero events from every driving timer merge onto the one pin level. This lets two timers with the same preload but offset start counts build waveforms whose duty cycle is not 50%. The pin keeps its level when a timer is stopped or reconfigured. It is forced low only when a driving timer is started again.

Top module: `tio_share_timers`

## Requirements
- R1: Reset clears every timer's control word (disabled, output mode 00, event select 00) and its count and preload. After reset, pin_out and pin_oe are both 0.
- R2: A write with wr_sel 00 loads the control word, 01 loads the preload and 10 loads the count, for the timer given by wr_tmr. In the control word, bit 0 is the enable, bits 2:1 are the output mode and bits 4:3 are the event select. An enabled timer decrements on each event. An event that arrives while the count is 0 or 1 reloads the preload and produces a zero event. This gives one zero event every preload events.
- R3: In output mode 10 (pulse), pin_out is 1 for exactly one clock after the edge at which the zero event occurs.
- R4: In output mode 11 (toggle), pin_out inverts at the edge at which each zero event occurs.
- R5: With several driving timers, any one of their zero events pulses or toggles the pin. Toggle events that occur at the same edge invert the pin once.
- R6: pin_oe is 1 exactly when at least one timer has output mode 10 or 11. Modes 00 and 01 do not drive the pin, and zero events from such timers leave pin_out unchanged.
- R7: Clearing a timer's enable, or changing its mode while it is disabled, leaves pin_out at its current level.
- R8: A control write that enables a disabled timer with output mode 10 or 11 drives pin_out to 0 at that edge.
- R9: With event select 11, a timer decrements once for each rising edge of pin_in, seen through a two-flop synchronizer, and ignores the internal clock. Event selects 00, 01 and 10 decrement on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_tmr | input | 2 | Timer index for the write |
| wr_sel | input | 2 | Register select: 00 control, 01 preload, 10 count |
| wr_data | input | 16 | Write data |
| pin_in | input | 1 | Level read back from the shared pin |
| pin_out | output | 1 | Level driven onto the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
The hardest cases to reach are the ones where two timers interact on the pin: offset zero events that set the duty cycle, and toggles that land on the same edge. Timers can only be enabled one write per clock, so the second timer always starts one cycle after the first. The stimulus therefore gives the first timer one extra count, which places both sequences on a known shared time base. The level-hold rule is reached by stopping a toggling timer while its pin is high, then removing its mode and enabling it again. The external-event path is driven by slow edges on pin_in that are held across many clocks, which shows that each edge gives exactly one decrement.

// File: rtl/tio_pkg.sv
package tio_pkg;

    typedef enum logic [1:0] {
        OM_INPUT  = 2'b00,
        OM_RSVD   = 2'b01,
        OM_PULSE  = 2'b10,
        OM_TOGGLE = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        ES_INT0 = 2'b00,
        ES_INT1 = 2'b01,
        ES_INT2 = 2'b10,
        ES_PIN  = 2'b11
    } evt_sel_e;

    typedef enum logic [1:0] {
        WS_CTRL    = 2'b00,
        WS_PRELOAD = 2'b01,
        WS_COUNT   = 2'b10,
        WS_NONE    = 2'b11
    } wr_sel_e;

    typedef struct packed {
        logic      en;
        out_mode_e mode;
        evt_sel_e  esel;
    } tmr_ctrl_t;

    localparam int CTRL_W   = 5;
    localparam int EN_BIT   = 0;
    localparam int MODE_LSB = 1;
    localparam int ESEL_LSB = 3;

    localparam tmr_ctrl_t CTRL_RESET = '{en: 1'b0, mode: OM_INPUT, esel: ES_INT0};

    function automatic tmr_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] raw);
        tmr_ctrl_t c;
        c.en   = raw[EN_BIT];
        c.mode = out_mode_e'(raw[MODE_LSB +: 2]);
        c.esel = evt_sel_e'(raw[ESEL_LSB +: 2]);
        return c;
    endfunction

    function automatic logic mode_drives(input out_mode_e m);
        return (m == OM_PULSE) || (m == OM_TOGGLE);
    endfunction

endpackage

// File: rtl/tio_evt_sync.sv
module tio_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tio_down_counter.sv
module tio_down_counter
    import tio_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_ctrl,
    input  logic             ld_pre,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ext_rise,
    output out_mode_e        mode,
    output logic             zero_hit,
    output logic             en_start
);
    tmr_ctrl_t        ctrl_q;
    tmr_ctrl_t        ctrl_new;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pre_q;
    logic             tick;
    logic             at_end;

    assign ctrl_new = unpack_ctrl(wdata[CTRL_W-1:0]);
    assign tick     = ctrl_q.en && ((ctrl_q.esel == ES_PIN) ? ext_rise : 1'b1);
    assign at_end   = (cnt_q <= CNT_W'(1));
    assign zero_hit = tick && at_end && !ld_cnt;
    assign en_start = ld_ctrl && ctrl_new.en && !ctrl_q.en && mode_drives(ctrl_new.mode);
    assign mode     = ctrl_q.mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            cnt_q  <= '0;
            pre_q  <= '0;
        end else begin
            if (ld_ctrl) ctrl_q <= ctrl_new;
            if (ld_pre)  pre_q  <= wdata;
            if (ld_cnt)        cnt_q <= wdata;
            else if (zero_hit) cnt_q <= pre_q;
            else if (tick)     cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tio_pin_ctrl.sv
module tio_pin_ctrl #(
    parameter int N_TMR = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_TMR-1:0] hit,
    input  logic [N_TMR-1:0] pulse_sel,
    input  logic [N_TMR-1:0] tog_sel,
    input  logic [N_TMR-1:0] start,
    output logic             pin_q,
    output logic             pulse_hit,
    output logic             tog_hit,
    output logic             start_any,
    output logic             pulse_pend
);
    assign pulse_hit = |(hit & pulse_sel);
    assign tog_hit   = |(hit & tog_sel);
    assign start_any = |start;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q      <= 1'b0;
            pulse_pend <= 1'b0;
        end else if (start_any) begin
            pin_q      <= 1'b0;
            pulse_pend <= 1'b0;
        end else if (tog_hit) begin
            pin_q      <= ~pin_q;
            pulse_pend <= 1'b0;
        end else if (pulse_hit) begin
            pin_q      <= 1'b1;
            pulse_pend <= 1'b1;
        end else if (pulse_pend) begin
            pin_q      <= 1'b0;
            pulse_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/tio_share_timers.sv
module tio_share_timers
    import tio_pkg::*;
#(
    parameter int N_TMR  = 3,
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2,
    localparam int TSEL_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TSEL_W-1:0] wr_tmr,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe
);
    logic             ext_rise;
    logic [N_TMR-1:0] hit;
    logic [N_TMR-1:0] start;
    logic [N_TMR-1:0] pulse_sel;
    logic [N_TMR-1:0] tog_sel;
    logic             pulse_hit;
    logic             tog_hit;
    logic             start_any;
    logic             pulse_pend;
    wr_sel_e          wsel;

    assign wsel = wr_sel_e'(wr_sel);

    tio_evt_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .rise   (ext_rise)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic      sel_me;
        out_mode_e mode_i;

        assign sel_me = wr_en && (wr_tmr == TSEL_W'(i));

        tio_down_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .ld_ctrl  (sel_me && (wsel == WS_CTRL)),
            .ld_pre   (sel_me && (wsel == WS_PRELOAD)),
            .ld_cnt   (sel_me && (wsel == WS_COUNT)),
            .wdata    (wr_data),
            .ext_rise (ext_rise),
            .mode     (mode_i),
            .zero_hit (hit[i]),
            .en_start (start[i])
        );

        assign pulse_sel[i] = (mode_i == OM_PULSE);
        assign tog_sel[i]   = (mode_i == OM_TOGGLE);
    end

    tio_pin_ctrl #(.N_TMR(N_TMR)) u_pin (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .pulse_sel  (pulse_sel),
        .tog_sel    (tog_sel),
        .start      (start),
        .pin_q      (pin_out),
        .pulse_hit  (pulse_hit),
        .tog_hit    (tog_hit),
        .start_any  (start_any),
        .pulse_pend (pulse_pend)
    );

    assign pin_oe = |(pulse_sel | tog_sel);
endmodule

// File: rtl/tio_share_checker.sv
module tio_share_checker (
    input logic clk,
    input logic rst,
    input logic pin_out,
    input logic pin_oe,
    input logic pulse_hit,
    input logic tog_hit,
    input logic start_any,
    input logic pulse_pend
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pin_out && !pin_oe));

    assert_pulse_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse_hit && !tog_hit && !start_any) |=> pin_out);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse_pend && !pulse_hit && !tog_hit && !start_any) |=> !pin_out);

    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (tog_hit && !start_any) |=> (pin_out != $past(pin_out)));

    assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!tog_hit && !pulse_hit && !pulse_pend && !start_any) |=> $stable(pin_out));

    assert_start_low_R8: assert property (@(posedge clk) disable iff (rst)
        start_any |=> !pin_out);
endmodule

bind tio_share_timers tio_share_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pulse_hit  (pulse_hit),
    .tog_hit    (tog_hit),
    .start_any  (start_any),
    .pulse_pend (pulse_pend)
);

// File: tb/tio_share_timers_tb.sv
module tio_share_timers_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_tmr = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tio_share_timers u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_tmr  (wr_tmr),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input int t, input int sel, input int data);
        wr_en   = 1'b1;
        wr_tmr  = 2'(t);
        wr_sel  = 2'(sel);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        pin_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "pin_out after reset", pin_out, 0);
        chk("R1", "pin_oe after reset", pin_oe, 0);
    endtask

    task automatic t_pulse();
        do_reset();
        wr(0, 2, 3); wr(0, 1, 4); wr(0, 0, 'h05);
        chk("R6", "pin_oe in pulse mode", pin_oe, 1);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk("R3", $sformatf("R2 pulse k=%0d", k), pin_out, int'(k >= 3 && (k - 3) % 4 == 0));
        end
    endtask

    task automatic t_toggle();
        do_reset();
        wr(1, 2, 2); wr(1, 1, 3); wr(1, 0, 'h0F);
        for (int k = 1; k <= 10; k++) begin
            int hits;
            @(negedge clk);
            hits = (k >= 2) ? (k - 2) / 3 + 1 : 0;
            chk("R4", $sformatf("R9 toggle es01 k=%0d", k), pin_out, hits % 2);
        end
    endtask

    task automatic t_duty();
        int highs = 0;
        do_reset();
        wr(0, 2, 2); wr(0, 1, 5); wr(1, 2, 3); wr(1, 1, 5);
        wr(0, 0, 'h07); wr(1, 0, 'h07);
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            highs += int'(pin_out);
            chk("R5", $sformatf("duty k=%0d", k), pin_out, int'(((k - 1) % 5) < 2));
        end
        chk("R5", "high cycles in 15", highs, 6);
    endtask

    task automatic t_pulse_or();
        do_reset();
        wr(0, 2, 2); wr(0, 1, 6); wr(1, 2, 4); wr(1, 1, 6);
        wr(0, 0, 'h05); wr(1, 0, 'h05);
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            chk("R5", $sformatf("merged pulse k=%0d", k), pin_out, int'((k - 1) % 3 == 0));
        end
    endtask

    task automatic t_simul();
        do_reset();
        wr(0, 2, 3); wr(0, 1, 4); wr(1, 2, 2); wr(1, 1, 4);
        wr(0, 0, 'h07); wr(1, 0, 'h07);
        for (int k = 1; k <= 12; k++) begin
            int hits;
            @(negedge clk);
            hits = (k >= 2) ? (k - 2) / 4 + 1 : 0;
            chk("R5", $sformatf("same-edge toggles k=%0d", k), pin_out, hits % 2);
        end
    endtask

    task automatic t_hold();
        do_reset();
        wr(0, 2, 1); wr(0, 1, 4); wr(0, 0, 'h07);
        @(negedge clk);
        chk("R4", "first toggle high", pin_out, 1);
        wr(0, 0, 'h06);
        for (int k = 0; k < 6; k++) begin
            chk("R7", $sformatf("held after disable c%0d", k), pin_out, 1);
            @(negedge clk);
        end
        chk("R6", "pin_oe while mode still 11", pin_oe, 1);
        wr(0, 0, 'h00);
        for (int k = 0; k < 4; k++) begin
            chk("R7", $sformatf("held after mode 00 c%0d", k), pin_out, 1);
            chk("R6", $sformatf("pin_oe off c%0d", k), pin_oe, 0);
            @(negedge clk);
        end
        wr(0, 0, 'h07);
        chk("R8", "low on re-enable", pin_out, 0);
        chk("R6", "pin_oe on re-enable", pin_oe, 1);
        repeat (3) @(negedge clk);
        chk("R8", "next toggle after re-enable", pin_out, 1);
    endtask

    task automatic t_input();
        do_reset();
        wr(0, 2, 1); wr(0, 1, 1); wr(1, 2, 1); wr(1, 1, 1);
        wr(0, 0, 'h01); wr(1, 0, 'h03);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R6", $sformatf("no drive oe c%0d", k), pin_oe, 0);
            chk("R6", $sformatf("no drive level c%0d", k), pin_out, 0);
        end
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            n += int'(pin_out);
        end
    endtask

    task automatic t_ext();
        int n;
        do_reset();
        wr(2, 2, 2); wr(2, 1, 2); wr(2, 0, 'h1D);
        count_pulses(10, n);
        chk("R9", "no count on clock", n, 0);
        pin_in = 1'b1;
        count_pulses(10, n);
        chk("R9", "first edge only decrements", n, 0);
        pin_in = 1'b0;
        count_pulses(5, n);
        chk("R9", "falling edge ignored", n, 0);
        pin_in = 1'b1;
        count_pulses(8, n);
        chk("R9", "second edge reaches zero", n, 1);
        count_pulses(8, n);
        chk("R9", "held high gives one event", n, 0);
    endtask

    task automatic t_reset_clears();
        wr(0, 2, 1); wr(0, 1, 1); wr(0, 0, 'h05);
        repeat (3) @(negedge clk);
        do_reset();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R1", $sformatf("cleared level c%0d", k), pin_out, 0);
            chk("R1", $sformatf("cleared oe c%0d", k), pin_oe, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pulse();
        t_toggle();
        t_duty();
        t_pulse_or();
        t_simul();
        t_hold();
        t_input();
        t_ext();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule